// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Engine

This block sits behind a CAN receiver. For every frame whose identifier has been received, it decides three things: whether the frame is kept, which of two receive FIFOs it goes to, and whether the host should get a high-priority notice. Two ordered lists of filter elements sit in local registers. The standard list compares 11-bit identifiers and the extended list compares 29-bit identifiers. The engine visits one element per clock, always starting at element 0, and stops at the first enabled element that matches.

Each element has a comparison kind and its own action. The kind is an inclusive range, a pair of exact identifiers, or a value with a care-mask. The action is accept or reject, a target FIFO, and a priority behaviour: no notice, notice with storage, or notice without storage. Three global inputs set the remaining policy. One decides the fate of frames that match no element. The other two discard remote frames, one for each identifier format.

Software fills the elements through a one-cycle write port. The receiver presents a frame with a single-cycle strobe and waits for the done pulse. A strobe that arrives while a search is still running is dropped and reported.

Top module: `caf_accept_filter`

## Requirements
- R1: After reset every element of both lists is disabled, and `busy_o`, `done_o` and `overrun_o` are low. A frame offered to empty lists is therefore treated as matching nothing.
- R2: The search starts at element 0 of the list that the frame's format selects and moves up one index per clock. The lowest-index enabled matching element decides the result. `done_o` pulses for one cycle exactly k+1 cycles after the strobe cycle when element k decides, and `hit_idx_o` then equals k.
- R3: A range element (kind field 2'b00) matches when ID1 <= identifier <= ID2, with both bounds included.
- R4: A dual element (kind field 2'b01) matches when the identifier equals ID1 or equals ID2.
- R5: A mask element (kind field 2'b10) matches when the identifier equals ID1 in every bit where ID2 is 1. An all-ones ID2 demands an exact match, and an all-zero ID2 matches every identifier.
- R6: An element with its enable bit (control bit 6) at 0, or with kind 2'b11, never matches, so the search continues past it.
- R7: On a matching element with its reject bit (control bit 3) set, the result is `accept_o`=0, `hprio_o`=0, `fifo_sel_o`=0 and `hit_o`=1. On a matching accepting element, `fifo_sel_o` equals its destination bit (control bit 2), where 0 means FIFO 0 and 1 means FIFO 1.
- R8: An accepting element with its priority bit (control bit 1) set raises `hprio_o`. If its no-store bit (control bit 0) is also set, `accept_o` is 0 while `hprio_o` stays 1. Without the priority bit, `hprio_o` is 0. The no-store bit alone clears `accept_o`.
- R9: When no element matches, `done_o` arrives a number of cycles after the strobe equal to the list length (28 standard, 8 extended). The result is then `hit_o`=0, `hit_idx_o`=0, `fifo_sel_o`=0, `hprio_o`=0, and `accept_o` equals the inverse of `rej_nomatch_i`.
- R10: A remote frame (`frm_rtr_i`=1) is rejected one cycle after its strobe, with `hit_o`=0, when the remote-reject input for its format is set (`rej_rtr_std_i` for standard, `rej_rtr_ext_i` for extended). The other format's setting has no effect on it.
- R11: A strobe that arrives while `busy_o` is high causes a one-cycle `overrun_o` pulse in the next cycle. That frame is never searched: only the running search produces a `done_o`.
- R12: Standard frames compare only identifier bits [10:0]. Bits [28:11] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Element write strobe |
| cfg_ext_i | input | 1 | Write target list: 0 standard, 1 extended |
| cfg_idx_i | input | 5 | Element index to write |
| cfg_ctrl_i | input | 7 | {enable, kind[1:0], reject, destination, priority, no-store} |
| cfg_id1_i | input | 29 | ID1 (low 11 bits used for the standard list) |
| cfg_id2_i | input | 29 | ID2 (low 11 bits used for the standard list) |
| rej_nomatch_i | input | 1 | Reject frames that match no element |
| rej_rtr_std_i | input | 1 | Reject all standard remote frames |
| rej_rtr_ext_i | input | 1 | Reject all extended remote frames |
| frm_vld_i | input | 1 | One-cycle strobe: identifier is ready |
| frm_id_i | input | 29 | Received identifier |
| frm_ext_i | input | 1 | Identifier is 29-bit |
| frm_rtr_i | input | 1 | Frame is a remote frame |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| accept_o | output | 1 | Frame is to be stored |
| fifo_sel_o | output | 1 | Destination FIFO |
| hprio_o | output | 1 | High-priority notification |
| hit_o | output | 1 | An element matched |
| hit_idx_o | output | 5 | Index of the matching element (0 when `hit_o` is 0) |
| overrun_o | output | 1 | Strobe dropped while busy |

## Verification
The hardest cases to reach from the ports are shadowing and skipping. A later element must lose to an earlier one that covers the same identifiers. A disabled element, or one of the unused kind, must be passed over even though its bounds would match everything. The stimulus loads a standard list in which elements overlap, an all-covering element is disabled, and the last slot holds a lone exact match. It then sweeps all 2048 standard identifiers, with garbage in the upper identifier bits, and compares the result and the latency of every frame against an arithmetic walk of the same list. The drop path is reached by strobing again while a 28-cycle search that matches nothing is still running.

// File: rtl/caf_pkg.sv
package caf_pkg;

  localparam int unsigned STD_ID_W = 11;
  localparam int unsigned EXT_ID_W = 29;

  typedef enum logic [1:0] {
    FK_RANGE = 2'b00,
    FK_DUAL  = 2'b01,
    FK_MASK  = 2'b10,
    FK_NONE  = 2'b11
  } flt_kind_e;

  typedef struct packed {
    logic      en;
    flt_kind_e kind;
    logic      rej;
    logic      dst;
    logic      hp;
    logic      nostore;
  } flt_ctrl_t;

  localparam int unsigned CTRL_W = $bits(flt_ctrl_t);

endpackage

// File: rtl/caf_elem_bank.sv
module caf_elem_bank
  import caf_pkg::*;
#(
  parameter int unsigned N     = 28,
  parameter int unsigned ID_W  = 11,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  flt_ctrl_t        wctrl_i,
  input  logic [ID_W-1:0]  wid1_i,
  input  logic [ID_W-1:0]  wid2_i,
  input  logic [IDX_W-1:0] ridx_i,
  output flt_ctrl_t        rctrl_o,
  output logic [ID_W-1:0]  rid1_o,
  output logic [ID_W-1:0]  rid2_o
);

  flt_ctrl_t       ctrl_q [N];
  logic [ID_W-1:0] id1_q  [N];
  logic [ID_W-1:0] id2_q  [N];

  for (genvar g = 0; g < N; g++) begin : g_elem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[g] <= '0;
        id1_q[g]  <= '0;
        id2_q[g]  <= '0;
      end else if (we_i && widx_i == IDX_W'(g)) begin
        ctrl_q[g] <= wctrl_i;
        id1_q[g]  <= wid1_i;
        id2_q[g]  <= wid2_i;
      end
    end
  end

  // index decode mux; out-of-list index reads as disabled
  always_comb begin
    rctrl_o = '0;
    rid1_o  = '0;
    rid2_o  = '0;
    for (int k = 0; k < N; k++) begin
      if (ridx_i == IDX_W'(k)) begin
        rctrl_o = ctrl_q[k];
        rid1_o  = id1_q[k];
        rid2_o  = id2_q[k];
      end
    end
  end

endmodule

// File: rtl/caf_match.sv
module caf_match
  import caf_pkg::*;
#(
  parameter int unsigned ID_W = 11
) (
  input  flt_kind_e       kind_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] id1_i,
  input  logic [ID_W-1:0] id2_i,
  output logic            hit_o
);

  always_comb begin
    unique case (kind_i)
      FK_RANGE: hit_o = (id_i >= id1_i) && (id_i <= id2_i);
      FK_DUAL:  hit_o = (id_i == id1_i) || (id_i == id2_i);
      FK_MASK:  hit_o = ~|((id_i ^ id1_i) & id2_i);
      default:  hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/caf_walker.sv
module caf_walker
  import caf_pkg::*;
#(
  parameter int unsigned STD_N = 28,
  parameter int unsigned EXT_N = 8,
  parameter int unsigned IDX_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frm_vld_i,
  input  logic [EXT_ID_W-1:0] frm_id_i,
  input  logic                frm_ext_i,
  input  logic                frm_rtr_i,
  input  logic                rej_nomatch_i,
  input  logic                rej_rtr_std_i,
  input  logic                rej_rtr_ext_i,
  input  flt_ctrl_t           elem_ctrl_i,
  input  logic                elem_hit_i,
  output logic [IDX_W-1:0]    scan_idx_o,
  output logic                scan_ext_o,
  output logic [EXT_ID_W-1:0] scan_id_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                accept_o,
  output logic                fifo_sel_o,
  output logic                hprio_o,
  output logic                hit_o,
  output logic [IDX_W-1:0]    hit_idx_o,
  output logic                overrun_o
);

  localparam logic [IDX_W-1:0] STD_LAST = IDX_W'(STD_N - 1);
  localparam logic [IDX_W-1:0] EXT_LAST = IDX_W'(EXT_N - 1);

  logic                busy_q, ext_q, kill_q;
  logic [IDX_W-1:0]    idx_q;
  logic [EXT_ID_W-1:0] id_q;
  logic                done_q, acc_q, sel_q, hp_q, hit_q, ovr_q;
  logic [IDX_W-1:0]    hidx_q;
  logic [IDX_W-1:0]    last_idx;
  logic                rtr_block;

  assign last_idx  = ext_q ? EXT_LAST : STD_LAST;
  assign rtr_block = frm_rtr_i && (frm_ext_i ? rej_rtr_ext_i : rej_rtr_std_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ext_q  <= 1'b0;
      kill_q <= 1'b0;
      idx_q  <= '0;
      id_q   <= '0;
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      sel_q  <= 1'b0;
      hp_q   <= 1'b0;
      hit_q  <= 1'b0;
      hidx_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      if (!busy_q) begin
        if (frm_vld_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          ext_q  <= frm_ext_i;
          id_q   <= frm_id_i;
          kill_q <= rtr_block;
        end
      end else begin
        ovr_q <= frm_vld_i;
        if (kill_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          acc_q  <= 1'b0;
          sel_q  <= 1'b0;
          hp_q   <= 1'b0;
          hit_q  <= 1'b0;
          hidx_q <= '0;
        end else if (elem_ctrl_i.en && elem_hit_i) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          acc_q  <= !elem_ctrl_i.rej && !elem_ctrl_i.nostore;
          sel_q  <= !elem_ctrl_i.rej && elem_ctrl_i.dst;
          hp_q   <= !elem_ctrl_i.rej && elem_ctrl_i.hp;
          hit_q  <= 1'b1;
          hidx_q <= idx_q;
        end else if (idx_q == last_idx) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          acc_q  <= !rej_nomatch_i;
          sel_q  <= 1'b0;
          hp_q   <= 1'b0;
          hit_q  <= 1'b0;
          hidx_q <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign scan_idx_o = idx_q;
  assign scan_ext_o = ext_q;
  assign scan_id_o  = id_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign accept_o   = acc_q;
  assign fifo_sel_o = sel_q;
  assign hprio_o    = hp_q;
  assign hit_o      = hit_q;
  assign hit_idx_o  = hidx_q;
  assign overrun_o  = ovr_q;

endmodule

// File: rtl/caf_accept_filter.sv
module caf_accept_filter
  import caf_pkg::*;
#(
  parameter int unsigned STD_N = 28,
  parameter int unsigned EXT_N = 8,
  localparam int unsigned MAX_N = (STD_N > EXT_N) ? STD_N : EXT_N,
  localparam int unsigned IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic                cfg_ext_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [CTRL_W-1:0]   cfg_ctrl_i,
  input  logic [EXT_ID_W-1:0] cfg_id1_i,
  input  logic [EXT_ID_W-1:0] cfg_id2_i,
  input  logic                rej_nomatch_i,
  input  logic                rej_rtr_std_i,
  input  logic                rej_rtr_ext_i,
  input  logic                frm_vld_i,
  input  logic [EXT_ID_W-1:0] frm_id_i,
  input  logic                frm_ext_i,
  input  logic                frm_rtr_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                accept_o,
  output logic                fifo_sel_o,
  output logic                hprio_o,
  output logic                hit_o,
  output logic [IDX_W-1:0]    hit_idx_o,
  output logic                overrun_o
);

  logic [IDX_W-1:0]    scan_idx;
  logic                scan_ext;
  logic [EXT_ID_W-1:0] scan_id;

  flt_ctrl_t           std_ctrl, ext_ctrl, elem_ctrl;
  logic [STD_ID_W-1:0] std_id1, std_id2;
  logic [EXT_ID_W-1:0] ext_id1, ext_id2;
  logic                std_hit, ext_hit, elem_hit;

  caf_elem_bank #(.N(STD_N), .ID_W(STD_ID_W), .IDX_W(IDX_W)) i_std_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && !cfg_ext_i),
    .widx_i  (cfg_idx_i),
    .wctrl_i (flt_ctrl_t'(cfg_ctrl_i)),
    .wid1_i  (cfg_id1_i[STD_ID_W-1:0]),
    .wid2_i  (cfg_id2_i[STD_ID_W-1:0]),
    .ridx_i  (scan_idx),
    .rctrl_o (std_ctrl),
    .rid1_o  (std_id1),
    .rid2_o  (std_id2)
  );

  caf_elem_bank #(.N(EXT_N), .ID_W(EXT_ID_W), .IDX_W(IDX_W)) i_ext_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && cfg_ext_i),
    .widx_i  (cfg_idx_i),
    .wctrl_i (flt_ctrl_t'(cfg_ctrl_i)),
    .wid1_i  (cfg_id1_i),
    .wid2_i  (cfg_id2_i),
    .ridx_i  (scan_idx),
    .rctrl_o (ext_ctrl),
    .rid1_o  (ext_id1),
    .rid2_o  (ext_id2)
  );

  caf_match #(.ID_W(STD_ID_W)) i_std_match (
    .kind_i (std_ctrl.kind),
    .id_i   (scan_id[STD_ID_W-1:0]),
    .id1_i  (std_id1),
    .id2_i  (std_id2),
    .hit_o  (std_hit)
  );

  caf_match #(.ID_W(EXT_ID_W)) i_ext_match (
    .kind_i (ext_ctrl.kind),
    .id_i   (scan_id),
    .id1_i  (ext_id1),
    .id2_i  (ext_id2),
    .hit_o  (ext_hit)
  );

  assign elem_ctrl = scan_ext ? ext_ctrl : std_ctrl;
  assign elem_hit  = scan_ext ? ext_hit  : std_hit;

  caf_walker #(.STD_N(STD_N), .EXT_N(EXT_N), .IDX_W(IDX_W)) i_walker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frm_vld_i     (frm_vld_i),
    .frm_id_i      (frm_id_i),
    .frm_ext_i     (frm_ext_i),
    .frm_rtr_i     (frm_rtr_i),
    .rej_nomatch_i (rej_nomatch_i),
    .rej_rtr_std_i (rej_rtr_std_i),
    .rej_rtr_ext_i (rej_rtr_ext_i),
    .elem_ctrl_i   (elem_ctrl),
    .elem_hit_i    (elem_hit),
    .scan_idx_o    (scan_idx),
    .scan_ext_o    (scan_ext),
    .scan_id_o     (scan_id),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .accept_o      (accept_o),
    .fifo_sel_o    (fifo_sel_o),
    .hprio_o       (hprio_o),
    .hit_o         (hit_o),
    .hit_idx_o     (hit_idx_o),
    .overrun_o     (overrun_o)
  );

endmodule

// File: rtl/caf_chk.sv
module caf_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frm_vld_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fifo_sel_o,
  input logic             hprio_o,
  input logic             hit_o,
  input logic [IDX_W-1:0] hit_idx_o,
  input logic             overrun_o
);

  // R2
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  // R2
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> ($past(busy_o) && $past(frm_vld_i)));

  // R11
  start_search_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && !busy_o) |=> busy_o);

  // R9
  nohit_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (hit_idx_o == '0 && !hprio_o && !fifo_sel_o));

  // R8
  hprio_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hprio_o) |-> hit_o);

endmodule

bind caf_accept_filter caf_chk #(.IDX_W(IDX_W)) i_caf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frm_vld_i  (frm_vld_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fifo_sel_o (fifo_sel_o),
  .hprio_o    (hprio_o),
  .hit_o      (hit_o),
  .hit_idx_o  (hit_idx_o),
  .overrun_o  (overrun_o)
);

// File: tb/test_caf_accept_filter.sv
module test_caf_accept_filter;

  localparam int CLK_PERIOD = 10;
  localparam int STD_N = 28;
  localparam int EXT_N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_ext = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [6:0]  cfg_ctrl = '0;
  logic [28:0] cfg_id1 = '0, cfg_id2 = '0;
  logic        rnm = 1'b0, rrs = 1'b0, rre = 1'b0;
  logic        vld = 1'b0, fext = 1'b0, frtr = 1'b0;
  logic [28:0] fid = '0;
  logic        busy, done, acc, sel, hp, hit, ovr;
  logic [4:0]  hidx;

  int checks = 0;
  int fails  = 0;

  logic [6:0]  m_ctrl [2][32];
  logic [28:0] m_id1  [2][32];
  logic [28:0] m_id2  [2][32];

  always #(CLK_PERIOD/2) clk = ~clk;

  caf_accept_filter i_caf_accept_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ext_i(cfg_ext), .cfg_idx_i(cfg_idx), .cfg_ctrl_i(cfg_ctrl),
    .cfg_id1_i(cfg_id1), .cfg_id2_i(cfg_id2),
    .rej_nomatch_i(rnm), .rej_rtr_std_i(rrs), .rej_rtr_ext_i(rre),
    .frm_vld_i(vld), .frm_id_i(fid), .frm_ext_i(fext), .frm_rtr_i(frtr),
    .busy_o(busy), .done_o(done), .accept_o(acc), .fifo_sel_o(sel), .hprio_o(hp),
    .hit_o(hit), .hit_idx_o(hidx), .overrun_o(ovr)
  );

  function automatic logic [6:0] mk(logic en, logic [1:0] k, logic rej, logic dst,
                                    logic hpr, logic ns);
    return {en, k, rej, dst, hpr, ns};
  endfunction

  task automatic check(input string tag, input logic ok, input string got, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %s expected %s", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic ext, input int idx, input logic [6:0] c,
                     input logic [28:0] a, input logic [28:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ext = ext; cfg_idx = 5'(idx); cfg_ctrl = c; cfg_id1 = a; cfg_id2 = b;
    @(negedge clk);
    cfg_we = 1'b0;
    m_ctrl[ext][idx] = c;
    m_id1[ext][idx]  = ext ? a : {18'd0, a[10:0]};
    m_id2[ext][idx]  = ext ? b : {18'd0, b[10:0]};
  endtask

  // expected result walked from the requirements
  task automatic model(input logic ext, input logic [28:0] id, input logic rtr,
                       output int lat, output logic e_acc, output logic e_sel,
                       output logic e_hp, output logic e_hit, output logic [4:0] e_idx);
    int n;
    logic [28:0] v;
    logic [6:0] c;
    logic m;
    n = ext ? EXT_N : STD_N;
    v = ext ? id : {18'd0, id[10:0]};
    e_acc = 0; e_sel = 0; e_hp = 0; e_hit = 0; e_idx = '0;
    if (rtr && (ext ? rre : rrs)) begin
      lat = 1;
      return;
    end
    for (int k = 0; k < n; k++) begin
      c = m_ctrl[ext][k];
      m = 1'b0;
      if (c[6]) begin
        case (c[5:4])
          2'b00: m = (v >= m_id1[ext][k]) && (v <= m_id2[ext][k]);
          2'b01: m = (v == m_id1[ext][k]) || (v == m_id2[ext][k]);
          2'b10: m = ((v & m_id2[ext][k]) == (m_id1[ext][k] & m_id2[ext][k]));
          default: m = 1'b0;
        endcase
      end
      if (m) begin
        lat = k + 1; e_hit = 1; e_idx = 5'(k);
        e_acc = !c[3] && !c[0];
        e_hp  = !c[3] && c[1];
        e_sel = !c[3] && c[2];
        return;
      end
    end
    lat = n;
    e_acc = !rnm;
  endtask

  task automatic run_frame(input logic ext, input logic [28:0] id, input logic rtr,
                           input string tag);
    int lat, cnt;
    logic ea, es, eh, ehit;
    logic [4:0] ei;
    model(ext, id, rtr, lat, ea, es, eh, ehit, ei);
    @(negedge clk);
    vld = 1'b1; fext = ext; fid = id; frtr = rtr;
    @(negedge clk);
    vld = 1'b0;
    cnt = 0;
    while (!done && cnt < 64) begin
      @(negedge clk);
      cnt++;
    end
    check(tag, cnt == lat && acc == ea && sel == es && hp == eh && hit == ehit && hidx == ei,
          $sformatf("lat=%0d acc=%b sel=%b hp=%b hit=%b idx=%0d (ext=%b id=%h)",
                    cnt, acc, sel, hp, hit, hidx, ext, id),
          $sformatf("lat=%0d acc=%b sel=%b hp=%b hit=%b idx=%0d", lat, ea, es, eh, ehit, ei));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < 2; e++)
      for (int k = 0; k < 32; k++) begin
        m_ctrl[e][k] = '0; m_id1[e][k] = '0; m_id2[e][k] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", busy == 0 && done == 0 && ovr == 0,
          $sformatf("busy=%b done=%b ovr=%b", busy, done, ovr), "0 0 0");
    // R1 R9 empty lists behave as no-match
    run_frame(1'b0, 29'h123, 1'b0, "R1/R9");
    run_frame(1'b1, 29'h1234567, 1'b0, "R1/R9");

    // standard list
    cfg(0, 0,  mk(1, 2'b00, 0, 1, 0, 0), 29'h100, 29'h10F);
    cfg(0, 1,  mk(1, 2'b01, 0, 0, 1, 0), 29'h005, 29'h7FF);
    cfg(0, 2,  mk(1, 2'b10, 1, 1, 1, 0), 29'h200, 29'h700);
    cfg(0, 3,  mk(0, 2'b00, 0, 1, 1, 0), 29'h000, 29'h7FF);
    cfg(0, 4,  mk(1, 2'b11, 0, 1, 1, 0), 29'h000, 29'h7FF);
    cfg(0, 5,  mk(1, 2'b10, 0, 1, 1, 1), 29'h250, 29'h7F0);
    cfg(0, 6,  mk(1, 2'b00, 0, 0, 0, 0), 29'h300, 29'h300);
    cfg(0, 7,  mk(1, 2'b10, 0, 1, 1, 1), 29'h400, 29'h400);
    cfg(0, 9,  mk(1, 2'b10, 0, 0, 0, 1), 29'h033, 29'h7FF);
    cfg(0, 27, mk(1, 2'b01, 0, 1, 0, 0), 29'h0AA, 29'h0AA);

    // R2 R3 R4 R5 R6 R7 R8 R12 full standard sweep, garbage upper bits
    for (int i = 0; i < 2048; i++)
      run_frame(1'b0, {18'h2A5A5, 11'(i)}, 1'b0, "R2/R3/R4/R5/R6/R7/R8/R12");

    // R9 reject non-matching
    rnm = 1'b1;
    run_frame(1'b0, 29'h001, 1'b0, "R9");
    run_frame(1'b0, 29'h3FF, 1'b0, "R9");
    rnm = 1'b0;

    // extended list
    cfg(1, 0, mk(1, 2'b10, 0, 1, 0, 0), 29'h1ABC0000, 29'h1FFF0000);
    cfg(1, 1, mk(1, 2'b00, 1, 0, 0, 0), 29'h00000010, 29'h00000020);
    cfg(1, 2, mk(1, 2'b01, 0, 0, 1, 0), 29'h1FFFFFFF, 29'h00000000);
    cfg(1, 4, mk(1, 2'b10, 0, 1, 0, 0), 29'h00000000, 29'h00000000);
    cfg(1, 4, mk(0, 2'b10, 0, 1, 0, 0), 29'h00000000, 29'h00000000);
    cfg(1, 7, mk(1, 2'b00, 0, 0, 0, 0), 29'h00000100, 29'h1FFFFFFF);

    // R3 R4 R5 extended boundaries
    run_frame(1'b1, 29'h0000000F, 1'b0, "R3");
    run_frame(1'b1, 29'h00000010, 1'b0, "R3");
    run_frame(1'b1, 29'h00000020, 1'b0, "R3");
    run_frame(1'b1, 29'h00000021, 1'b0, "R3");
    run_frame(1'b1, 29'h000000FF, 1'b0, "R3");
    run_frame(1'b1, 29'h00000100, 1'b0, "R3");
    run_frame(1'b1, 29'h1ABBFFFF, 1'b0, "R5");
    run_frame(1'b1, 29'h1ABC0000, 1'b0, "R5");
    run_frame(1'b1, 29'h1ABCFFFF, 1'b0, "R5");
    run_frame(1'b1, 29'h1ABD0000, 1'b0, "R5");
    run_frame(1'b1, 29'h1FFFFFFF, 1'b0, "R4");
    run_frame(1'b1, 29'h00000000, 1'b0, "R4");
    for (int i = 0; i < 256; i++)
      run_frame(1'b1, 29'((i * 32'h0123_4567) ^ (i << 21)), 1'b0, "R2/R3/R4/R5/R6");

    // R10 remote frames per format
    rrs = 1'b1; rre = 1'b0;
    run_frame(1'b0, 29'h105, 1'b1, "R10");
    run_frame(1'b1, 29'h1ABC0001, 1'b1, "R10");
    rrs = 1'b0; rre = 1'b1;
    run_frame(1'b0, 29'h105, 1'b1, "R10");
    run_frame(1'b1, 29'h1ABC0001, 1'b1, "R10");
    rre = 1'b0;

    // R11 overrun: second strobe during a long no-match search
    begin
      int lat, cnt, dones;
      logic ea, es, eh, ehit;
      logic [4:0] ei;
      model(1'b0, 29'h001, 1'b0, lat, ea, es, eh, ehit, ei);
      @(negedge clk);
      vld = 1'b1; fext = 1'b0; fid = 29'h001; frtr = 1'b0;
      @(negedge clk);
      vld = 1'b1; fid = 29'h105;
      @(negedge clk);
      vld = 1'b0;
      check("R11", ovr == 1'b1, $sformatf("ovr=%b", ovr), "ovr=1");
      cnt = 1;
      while (!done && cnt < 64) begin
        @(negedge clk);
        cnt++;
      end
      check("R11", cnt == lat && hit == ehit && acc == ea,
            $sformatf("lat=%0d hit=%b acc=%b", cnt, hit, acc),
            $sformatf("lat=%0d hit=%b acc=%b", lat, ehit, ea));
      dones = 0;
      for (int w = 0; w < 40; w++) begin
        @(negedge clk);
        if (done || busy) dones++;
      end
      check("R11", dones == 0, $sformatf("extra activity=%0d", dones), "0");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule